// File: doc/BRIEF.md
# Double-Width Integer Divider

This unit divides a dividend of twice the data width, supplied as a high half and a low half, by a single-width divisor. One operation yields a single-width quotient and a single-width remainder. A per-request mode bit selects unsigned or two's complement signed operands. Internally a restoring shift-subtract loop works on magnitudes. In signed mode the signs are applied afterwards, so the quotient truncates toward zero and the remainder takes the dividend's sign.

A request is made by pulsing `start_i` while the unit is idle. The unit then stays busy for a fixed number of cycles and pulses `done_o` with the results. A quotient that does not fit the data width raises `fault_o`, and so does a zero divisor. On a fault the previous quotient and remainder are kept on the outputs.

Top module: `wide_divider`

## Requirements
- R1: In unsigned mode (`signed_i`=0) the dividend is {`dvd_hi_i`,`dvd_lo_i`}. When no fault occurs, `quot_o` is floor(dividend/divisor) and `rem_o` is dividend minus quotient times divisor.
- R2: In signed mode (`signed_i`=1) both operands are two's complement. The quotient is the exact ratio truncated toward zero, for example -7/2 gives -3 and not -4.
- R3: In signed mode a nonzero remainder has the sign of the dividend and a magnitude below that of the divisor. For -48 divided by 5 at width 8, the result is quotient -9 (0xF7) and remainder -3 (0xFD).
- R4: When the true quotient does not fit in W bits (unsigned above 2^W-1, signed outside -2^(W-1)..2^(W-1)-1), `fault_o` is 1 in the done cycle and `quot_o`/`rem_o` keep their previous values.
- R5: A zero divisor gives `fault_o`=1 in the done cycle, with `quot_o`/`rem_o` unchanged.
- R6: Latency is fixed at W+2 cycles. If `start_i` is sampled at clock edge k, `done_o` is high after edge k+W+1.
- R7: `done_o` is high for exactly one cycle per accepted request. `busy_o` is high from the edge that samples `start_i` until the edge at which `done_o` rises.
- R8: `start_i` has no effect while `busy_o` is 1. The running operation's results are unchanged and no extra `done_o` pulse occurs.
- R9: After reset `busy_o`, `done_o` and `fault_o` are 0, and `quot_o` and `rem_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, honoured only when idle |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| dvd_hi_i | input | W | Upper half of dividend |
| dvd_lo_i | input | W | Lower half of dividend |
| dvsr_i | input | W | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Overflow or zero divisor, valid with done_o |
| quot_o | output | W | Quotient |
| rem_o | output | W | Remainder |

## Verification
The bench targets the signed range edges. -1024/8 must give -128 without a fault, while 1024/8 must fault. A design that compared the magnitude against a single limit for both signs would get one of these wrong. Mixed-sign operands and -7/2 expose rounding toward negative infinity and a remainder that takes the divisor's sign. Zero divisors, high halves at or above the divisor, and starts issued mid-operation show whether a unit clobbers held results, truncates silently, or restarts on a busy start.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Converts operands to magnitudes and flags quotients too wide for the loop.
module div_prep #(
  parameter int W = 16
) (
  input  logic           signed_i,
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   dvsr_i,
  output logic [2*W-1:0] dvd_mag_o,
  output logic [W-1:0]   dvsr_mag_o,
  output logic           neg_q_o,
  output logic           neg_r_o,
  output logic           pre_ovf_o
);
  logic [2*W-1:0] dvd;
  logic           dvd_neg;
  logic           dvs_neg;

  always_comb begin
    dvd        = {hi_i, lo_i};
    dvd_neg    = signed_i & dvd[2*W-1];
    dvs_neg    = signed_i & dvsr_i[W-1];
    dvd_mag_o  = dvd_neg ? (~dvd + 1'b1) : dvd;
    dvsr_mag_o = dvs_neg ? (~dvsr_i + 1'b1) : dvsr_i;
    neg_q_o    = dvd_neg ^ dvs_neg;
    neg_r_o    = dvd_neg;
    // quotient magnitude >= 2^W (also catches a zero divisor)
    pre_ovf_o  = dvd_mag_o[2*W-1:W] >= dvsr_mag_o;
  end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract loop, one quotient bit per step.
module div_core #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvsr_i,
  output logic           last_o,
  output logic [W-1:0]   q_o,
  output logic [W-1:0]   r_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  r_q, q_q, d_q;
  logic [CW-1:0] cnt_q;
  logic          rng_ok_q;
  logic [W-1:0]  t_lo;
  logic          ge;
  logic [W-1:0]  r_nxt;

  always_comb begin
    t_lo  = {r_q[W-2:0], q_q[W-1]};
    ge    = r_q[W-1] | (t_lo >= d_q);
    r_nxt = ge ? (t_lo - d_q) : t_lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q      <= '0;
      q_q      <= '0;
      d_q      <= '0;
      cnt_q    <= '0;
      rng_ok_q <= 1'b0;
    end else if (load_i) begin
      r_q      <= dvd_i[2*W-1:W];
      q_q      <= dvd_i[W-1:0];
      d_q      <= dvsr_i;
      cnt_q    <= '0;
      rng_ok_q <= dvd_i[2*W-1:W] < dvsr_i;
    end else if (step_i) begin
      r_q   <= r_nxt;
      q_q   <= {q_q[W-2:0], ge};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = step_i && (cnt_q == LAST);
  assign q_o    = q_q;
  assign r_o    = r_q;

  // R1: partial remainder stays below divisor when the range precheck passed
  assert_rem_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && rng_ok_q |-> r_q < d_q);
  // R8: divisor held while iterating
  assert_operand_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(d_q));
endmodule

// File: rtl/div_fix.sv
// Applies signs and detects signed range overflow.
module div_fix #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  input  logic         pre_ovf_i,
  input  logic [W-1:0] q_mag_i,
  input  logic [W-1:0] r_mag_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o,
  output logic         fault_o
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};
  logic post_ovf;

  always_comb begin
    q_o      = neg_q_i ? (~q_mag_i + 1'b1) : q_mag_i;
    r_o      = neg_r_i ? (~r_mag_i + 1'b1) : r_mag_i;
    post_ovf = signed_i & (neg_q_i ? (q_mag_i > HALF) : (q_mag_i >= HALF));
    fault_o  = pre_ovf_i | post_ovf;
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvsr_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         fault_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  div_state_e     st_q;
  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dvsr_mag;
  logic           neg_q, neg_r, pre_ovf;
  logic           neg_q_q, neg_r_q, pre_ovf_q, sgn_q, dz_q;
  logic           load, step, last;
  logic [W-1:0]   q_mag, r_mag, q_fix, r_fix;
  logic           fault_fix;
  logic           done_q, fault_q;
  logic [W-1:0]   quot_q, rem_q;

  div_prep #(.W(W)) u_prep (
    .signed_i   (signed_i),
    .hi_i       (dvd_hi_i),
    .lo_i       (dvd_lo_i),
    .dvsr_i     (dvsr_i),
    .dvd_mag_o  (dvd_mag),
    .dvsr_mag_o (dvsr_mag),
    .neg_q_o    (neg_q),
    .neg_r_o    (neg_r),
    .pre_ovf_o  (pre_ovf)
  );

  assign load = (st_q == ST_IDLE) && start_i;
  assign step = (st_q == ST_RUN);

  div_core #(.W(W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .dvd_i  (dvd_mag),
    .dvsr_i (dvsr_mag),
    .last_o (last),
    .q_o    (q_mag),
    .r_o    (r_mag)
  );

  div_fix #(.W(W)) u_fix (
    .signed_i  (sgn_q),
    .neg_q_i   (neg_q_q),
    .neg_r_i   (neg_r_q),
    .pre_ovf_i (pre_ovf_q),
    .q_mag_i   (q_mag),
    .r_mag_i   (r_mag),
    .q_o       (q_fix),
    .r_o       (r_fix),
    .fault_o   (fault_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      pre_ovf_q <= 1'b0;
      sgn_q     <= 1'b0;
      dz_q      <= 1'b0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      quot_q    <= '0;
      rem_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q      <= ST_RUN;
          neg_q_q   <= neg_q;
          neg_r_q   <= neg_r;
          pre_ovf_q <= pre_ovf;
          sgn_q     <= signed_i;
          dz_q      <= (dvsr_i == '0);
        end
        ST_RUN: if (last) st_q <= ST_FIX;
        ST_FIX: begin
          st_q    <= ST_IDLE;
          done_q  <= 1'b1;
          fault_q <= fault_fix;
          if (!fault_fix) begin
            quot_q <= q_fix;
            rem_q  <= r_fix;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign quot_o  = quot_q;
  assign rem_o   = rem_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o) && !busy_o);
  assert_fault_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> $stable(quot_o) && $stable(rem_o));
  assert_zero_div_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dz_q |-> fault_o);
endmodule

// File: tb/wide_divider_bench.sv
module wide_divider_bench;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         f;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sgn = 1'b0;
  logic [W-1:0] hi = '0, lo = '0, dv = '0;
  logic         busy, done, fault;
  logic [W-1:0] quot, rem;

  int total = 0;
  int bad = 0;
  int pushes = 0;
  int dones = 0;
  int cyc = 0;
  logic prev_done = 1'b0;
  logic [W-1:0] last_q = '0, last_r = '0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  wide_divider #(.W(W)) u_wide_divider (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvsr_i(dv),
    .busy_o(busy), .done_o(done), .fault_o(fault), .quot_o(quot), .rem_o(rem)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] h, input logic [W-1:0] l,
                                 input logic [W-1:0] d, input logic s, input string tag);
    exp_t e;
    longint n, m, qq, rr, qmin, qmax;
    if (s) begin
      n = longint'($signed({h, l}));
      m = longint'($signed(d));
      qmin = -(longint'(1) <<< (W-1));
      qmax = (longint'(1) <<< (W-1)) - 1;
    end else begin
      n = longint'({h, l});
      m = longint'(d);
      qmin = 0;
      qmax = (longint'(1) <<< W) - 1;
    end
    e.tag = tag;
    if (m == 0) begin
      e.f = 1'b1; e.q = last_q; e.r = last_r;
    end else begin
      qq = n / m;
      rr = n % m;
      if (qq > qmax || qq < qmin) begin
        e.f = 1'b1; e.q = last_q; e.r = last_r;
      end else begin
        e.f = 1'b0; e.q = qq[W-1:0]; e.r = rr[W-1:0];
      end
    end
    return e;
  endfunction

  task automatic op(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d,
                    input logic s, input bit interfere, input string tag);
    exp_t e;
    int k;
    bit busy_ok;
    e = model(h, l, d, s, tag);
    if (!e.f) begin last_q = e.q; last_r = e.r; end
    @(negedge clk);
    hi = h; lo = l; dv = d; sgn = s; start = 1'b1;
    exp_q.push_back(e);
    pushes++;
    k = 0;
    busy_ok = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      k++;
      if (interfere && k == 3) begin
        // R8: start while busy with different operands
        start = 1'b1; hi = ~h; lo = ~l; dv = d + 8'd3; sgn = ~s;
      end
      if (done) break;
      if (!busy) busy_ok = 1'b0;
      if (k > 4 * W) break;
    end
    start = 1'b0;
    chk(k == W + 2, {"R6 latency ", tag}, k, W + 2);
    chk(busy_ok, {"R7 busy during op ", tag}, busy_ok, 1);
    @(negedge clk);
    chk(!busy && !done, {"R7 idle after done ", tag}, {busy, done}, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) chk(1'b0, "R7 done longer than one cycle", 1, 0);
      if (done) begin
        exp_t e;
        dones++;
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(fault == e.f, {e.tag, " fault"}, fault, e.f);
          chk(quot == e.q, {e.tag, " quot"}, quot, e.q);
          chk(rem == e.r, {e.tag, " rem"}, rem, e.r);
        end
      end
      prev_done = done;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault, "R9 reset flags", {busy, done, fault}, 0);
    chk(quot == 0 && rem == 0, "R9 reset data", {quot, rem}, 0);

    op(8'hFF, 8'hD0, 8'h05, 1'b1, 1'b0, "R3 -48/5");
    op(8'h03, 8'hE8, 8'h07, 1'b0, 1'b0, "R1 1000/7");
    op(8'h07, 8'h00, 8'h07, 1'b0, 1'b0, "R4 unsigned hi>=d");
    op(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, "R5 zero unsigned");
    op(8'hFF, 8'hF9, 8'h02, 1'b1, 1'b0, "R2 -7/2");
    op(8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, "R5 zero signed");
    op(8'hFC, 8'h00, 8'h08, 1'b1, 1'b0, "R4 -1024/8 edge");
    op(8'h04, 8'h00, 8'h08, 1'b1, 1'b0, "R4 1024/8 ovf");
    op(8'h00, 8'h64, 8'hF9, 1'b1, 1'b0, "R2 100/-7");
    op(8'hFF, 8'h9C, 8'hF9, 1'b1, 1'b0, "R3 -100/-7");
    op(8'hFE, 8'hFF, 8'hFF, 1'b0, 1'b0, "R1 max unsigned");
    op(8'h12, 8'h34, 8'h56, 1'b0, 1'b1, "R8 start while busy");
    op(8'hFF, 8'hD0, 8'h05, 1'b1, 1'b1, "R8 signed start while busy");

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] rh, rl, rd;
      logic rs;
      rs = 1'(i & 1);
      rl = 8'($urandom);
      rd = 8'($urandom);
      rh = (i % 3 == 0) ? 8'($urandom) : (rs ? {8{rl[7]}} : 8'($urandom_range(0, 3)));
      op(rh, rl, rd, rs, 1'b0, rs ? "R2 random signed" : "R1 random unsigned");
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && dones == pushes, "R8 done count", dones, pushes);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule